// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block models a flow-through synchronous static RAM whose bus can go from a write straight to a read with no idle cycle between them. Every operation starts on a rising clock edge. An access is opened by a start edge that carries an address. Later edges can continue it as a burst of up to four beats without a new address. When the access is a read, the addressed word is driven onto the data bus during the cycle that follows the start edge. When the access is a write, its data arrives one clock later than its address and is taken at the next rising edge. The bus is therefore free on the cycle right after a read and can carry write data there.

Each write first lands in a one-entry pending register and moves into the storage array at the following enabled edge. A read of the same address in between returns the pending lanes over the stored ones. A global stall input freezes everything, and an asynchronous output enable gates the bus drivers. Three chip selects, two active low and one active high, must all be active for a start edge to open an access. Otherwise the edge deselects the device.

Top module: `zt_sram`

## Requirements
- R1: While `stall` is high at a rising edge, that edge has no effect. The access in flight, its burst position, any write data still owed and the pending write all stay as they were.
- R2: When `stall` is low, `start_n` is low and all three selects are active (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0), the edge opens an access at `adr`. With `wr_n` high the access is a read, and the stored word at `adr` appears on `data` in the cycle after that edge.
- R3: `out_en_n` high forces `data` to high impedance at once, without waiting for a clock, even while a read is in flight. Lowering it brings the read word back in the same cycle.
- R4: With `wr_n` low at the start edge the access is a write. The device leaves `data` undriven during the following cycle whatever `out_en_n` is, and it captures the bus at the next enabled edge.
- R5: `lane_wr_n[i]` is sampled on the same edge as the beat address. When it is low, lane i (bits 9i+8 down to 9i, with bit 9i+8 as that lane's parity bit) is written. Lanes whose bit is high keep their old contents.
- R6: A start edge with any select inactive deselects the device. `data` is undriven in the next cycle, and bus activity during that cycle writes nothing.
- R7: A read issued on the edge that captures a write's data, or on any later edge, returns the newly written lanes with no idle cycle. This holds both for the same address and while another write is still pending.
- R8: With `burst_order` low, each edge with `start_n` high advances the burst and keeps the read or write type. Beat n uses the start address with its two low bits replaced by (low bits + n) mod 4.
- R9: With `burst_order` high, beat n uses the start address with its two low bits replaced by (low bits XOR n).
- R10: An advance edge after a deselect leaves the device deselected, with `data` undriven.
- R11: While and after `rst_n` is low, the device is deselected, no write is pending and `data` is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| stall | input | 1 | High: ignore this clock edge entirely |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| start_n | input | 1 | Low: start or deselect; high: advance burst |
| wr_n | input | 1 | Low at a start edge: write access |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| burst_order | input | 1 | 0 linear, 1 interleaved beat order |
| adr | input | AW (6) | Word address |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| data | inout | 36 | Four 9-bit lanes, each eight data bits and one parity bit |

## Verification
The hardest case to reach from the ports is a read that meets a write still in the pending register with only some lanes enabled. It needs a write start, then its data beat, then a read start on the very next edge. The bench runs that three-edge sequence once for each of the sixteen lane masks. It also inserts stalled edges between a write address and its data, checks that the frozen write later captures the real data and not the bytes present during the stall, and issues a read behind a second pending write so that the commit path and the bypass path are both exercised.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low two address bits of burst beat n
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] n,
                                             input logic       interleave);
    logic [1:0] r;
    if (interleave) r = start ^ n;
    else            r = start + n;
    return r;
  endfunction

endpackage

// File: rtl/zt_ctrl.sv
module zt_ctrl
  import zt_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             sel_all,
  input  logic             start_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             burst_order,
  input  logic [AW-1:0]    adr,
  output op_e              cur_op,
  output logic [AW-1:0]    eff_adr,
  output logic [LANES-1:0] cur_lanes,
  output logic             ev_load,
  output logic             ev_desel,
  output logic             ev_adv,
  output logic             ev_capture
);

  op_e              op_q;
  logic [AW-1:0]    base_q;
  logic [1:0]       cnt_q;
  logic [LANES-1:0] lanes_q;

  assign ev_load    = step && !start_n && sel_all;
  assign ev_desel   = step && !start_n && !sel_all;
  assign ev_adv     = step && start_n;
  assign ev_capture = step && (op_q == OP_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      base_q  <= '0;
      cnt_q   <= '0;
      lanes_q <= '0;
    end else if (step) begin
      lanes_q <= ~lane_wr_n;
      if (!start_n) begin
        base_q <= adr;
        cnt_q  <= '0;
        if (!sel_all)   op_q <= OP_IDLE;
        else if (wr_n)  op_q <= OP_READ;
        else            op_q <= OP_WRITE;
      end else begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign cur_op    = op_q;
  assign cur_lanes = lanes_q;
  assign eff_adr   = {base_q[AW-1:2], beat_offset(base_q[1:0], cnt_q, burst_order)};

endmodule

// File: rtl/zt_pend.sv
module zt_pend #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              capture,
  input  logic [AW-1:0]     cap_adr,
  input  logic [LANES-1:0]  cap_lanes,
  input  logic [WORD_W-1:0] cap_data,
  output logic              pend_valid,
  output logic [AW-1:0]     pend_adr,
  output logic [LANES-1:0]  pend_lanes,
  output logic [WORD_W-1:0] pend_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend_valid <= 1'b0;
    else if (step) pend_valid <= capture;
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      pend_adr   <= cap_adr;
      pend_lanes <= cap_lanes;
      pend_data  <= cap_data;
    end
  end

endmodule

// File: rtl/zt_array.sv
module zt_array #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << AW
) (
  input  logic              clk,
  input  logic              commit,
  input  logic              pend_valid,
  input  logic [AW-1:0]     pend_adr,
  input  logic [LANES-1:0]  pend_lanes,
  input  logic [WORD_W-1:0] pend_data,
  input  logic [AW-1:0]     rd_adr,
  output logic [WORD_W-1:0] rd_data
);

  logic bypass_hit;
  assign bypass_hit = pend_valid && (pend_adr == rd_adr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] pend_slice;

    assign pend_slice = pend_data[g*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (commit && pend_lanes[g]) store[pend_adr] <= pend_slice;
    end

    assign rd_data[g*LANE_W +: LANE_W] =
      (bypass_hit && pend_lanes[g]) ? pend_slice : store[rd_adr];
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              start_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              burst_order,
  input  logic [AW-1:0]     adr,
  input  logic              out_en_n,
  inout  wire  [WORD_W-1:0] data
);

  logic              step;
  logic              sel_all;
  op_e               cur_op;
  logic [AW-1:0]     eff_adr;
  logic [LANES-1:0]  cur_lanes;
  logic              ev_load, ev_desel, ev_adv, ev_capture;
  logic              pend_valid;
  logic [AW-1:0]     pend_adr;
  logic [LANES-1:0]  pend_lanes;
  logic [WORD_W-1:0] pend_data;
  logic              commit;
  logic [WORD_W-1:0] rd_data;
  logic              bus_drive;

  assign step      = !stall;
  assign sel_all   = !sel_a_n && sel_b && !sel_c_n;
  assign commit    = step && pend_valid;
  assign bus_drive = (cur_op == OP_READ) && !out_en_n;
  assign data      = bus_drive ? rd_data : {WORD_W{1'bz}};

  zt_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (step),
    .sel_all     (sel_all),
    .start_n     (start_n),
    .wr_n        (wr_n),
    .lane_wr_n   (lane_wr_n),
    .burst_order (burst_order),
    .adr         (adr),
    .cur_op      (cur_op),
    .eff_adr     (eff_adr),
    .cur_lanes   (cur_lanes),
    .ev_load     (ev_load),
    .ev_desel    (ev_desel),
    .ev_adv      (ev_adv),
    .ev_capture  (ev_capture)
  );

  zt_pend #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .capture    (ev_capture),
    .cap_adr    (eff_adr),
    .cap_lanes  (cur_lanes),
    .cap_data   (data),
    .pend_valid (pend_valid),
    .pend_adr   (pend_adr),
    .pend_lanes (pend_lanes),
    .pend_data  (pend_data)
  );

  zt_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk        (clk),
    .commit     (commit),
    .pend_valid (pend_valid),
    .pend_adr   (pend_adr),
    .pend_lanes (pend_lanes),
    .pend_data  (pend_data),
    .rd_adr     (eff_adr),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
  import zt_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          out_en_n,
  input logic [AW-1:0] adr,
  input op_e           cur_op,
  input logic [AW-1:0] eff_adr,
  input logic          bus_drive,
  input logic          pend_valid,
  input logic [AW-1:0] pend_adr,
  input logic          ev_load,
  input logic          ev_desel,
  input logic          ev_adv,
  input logic          ev_capture
);

  p_freeze_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(cur_op) && $stable(eff_adr) && $stable(pend_valid));

  p_load_adr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> (cur_op != OP_IDLE) && (eff_adr == $past(adr)));

  p_oe_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !bus_drive);

  p_write_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_op == OP_WRITE) |-> !bus_drive);

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |=> pend_valid && (pend_adr == $past(eff_adr)));

  p_desel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desel |=> (cur_op == OP_IDLE) && !bus_drive);

  p_adv_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_adv |=> cur_op == $past(cur_op));

  p_adv_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_adv && cur_op == OP_IDLE) |=> (cur_op == OP_IDLE) && !bus_drive);

endmodule

bind zt_sram zt_sram_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stall      (stall),
  .out_en_n   (out_en_n),
  .adr        (adr),
  .cur_op     (cur_op),
  .eff_adr    (eff_adr),
  .bus_drive  (bus_drive),
  .pend_valid (pend_valid),
  .pend_adr   (pend_adr),
  .ev_load    (ev_load),
  .ev_desel   (ev_desel),
  .ev_adv     (ev_adv),
  .ev_capture (ev_capture)
);

// File: tb/sim_zt_sram.sv
module sim_zt_sram;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall;
  logic        sel_a_n, sel_b, sel_c_n;
  logic        start_n, wr_n;
  logic [3:0]  lane_wr_n;
  logic        burst_order;
  logic [5:0]  adr;
  logic        out_en_n;
  logic [35:0] tb_dq;
  logic        tb_drive;
  wire  [35:0] data;

  logic [35:0] model [NW];
  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  assign data = tb_drive ? tb_dq : {36{1'bz}};

  always #(CLK_PERIOD/2) clk = ~clk;

  zt_sram u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .start_n(start_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .burst_order(burst_order), .adr(adr), .out_en_n(out_en_n),
    .data(data)
  );

  function automatic logic [35:0] pat(input int a, input int s);
    return {4'(s), 8'(a * 7 + s), 8'(a ^ 165), 8'(a + s * 3), 8'(255 - a)};
  endfunction

  function automatic logic [35:0] mix(input logic [35:0] old, input logic [35:0] nw,
                                      input logic [3:0] en);
    logic [35:0] r = 36'd0;
    for (int i = 0; i < 36; i++) r[i] = en[i / 9] ? nw[i] : old[i];
    return r;
  endfunction

  function automatic int beat_adr(input int base, input int n, input bit intl);
    int lo = base % 4;
    int off = intl ? (lo ^ n) : ((lo + n) % 4);
    return base - lo + off;
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic op_load(input int a, input bit wr, input logic [3:0] en);
    start_n = 1'b0; sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    wr_n = !wr; lane_wr_n = ~en; adr = 6'(a);
  endtask

  task automatic op_adv(input logic [3:0] en);
    start_n = 1'b1; lane_wr_n = ~en;
  endtask

  task automatic op_desel();
    start_n = 1'b0; sel_a_n = 1'b1; sel_b = 1'b1; sel_c_n = 1'b0;
  endtask

  task automatic expect_hiz(input string tag);
    tb_dq = 36'd0; tb_drive = 1'b1; #1;
    check(tag, data, 36'd0);
    tb_drive = 1'b0; #1;
  endtask

  task automatic bwrite(input int base, input bit intl, input int salt);
    burst_order = intl;
    op_load(base, 1'b1, 4'hF); tick();
    for (int n = 0; n < 4; n++) begin
      int a = beat_adr(base, n, intl);
      tb_dq = pat(a, salt); tb_drive = 1'b1; model[a] = tb_dq;
      if (n < 3) op_adv(4'hF); else op_desel();
      tick();
    end
    tb_drive = 1'b0;
  endtask

  task automatic bread(input int base, input bit intl);
    burst_order = intl;
    op_load(base, 1'b0, 4'h0); tick(); #1;
    for (int n = 0; n < 4; n++) begin
      int a = beat_adr(base, n, intl);
      check(intl ? "R9 interleaved beat / R2" : "R8 linear beat / R2", data, model[a]);
      if (n < 3) op_adv(4'h0); else op_desel();
      tick(); #1;
    end
  endtask

  task automatic wr_rd(input int a, input logic [3:0] en, input logic [35:0] d);
    op_load(a, 1'b1, en); tick();
    expect_hiz("R4 bus released in write cycle");
    tb_dq = d; tb_drive = 1'b1; model[a] = mix(model[a], d, en);
    op_load(a, 1'b0, 4'h0); tick();
    tb_drive = 1'b0; #1;
    check("R5/R7 lane-merged read after write", data, model[a]);
    op_desel(); tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stall = 1'b0; tb_drive = 1'b0; tb_dq = '0;
    burst_order = 1'b0; out_en_n = 1'b0;
    op_desel(); wr_n = 1'b1; lane_wr_n = 4'hF; adr = '0;
    repeat (3) tick();
    expect_hiz("R11 undriven in reset");
    rst_n = 1'b1;
    tick();
    expect_hiz("R11 undriven after reset");

    // fill all words with aligned linear bursts
    for (int b = 0; b < NW; b += 4) bwrite(b, 1'b0, 1);
    // every start position in both orders
    for (int b = 0; b < NW; b++) bread(b, 1'b0);
    for (int b = 0; b < NW; b++) bread(b, 1'b1);
    // interleaved write from an unaligned start, then read linearly
    bwrite(22, 1'b1, 2);
    bread(20, 1'b0);

    // all lane masks, read on the edge that captures the data
    for (int m = 0; m < 16; m++) wr_rd(9, 4'(m), pat(9, 16 + m));

    // R7: read while another write is pending, then after commit
    op_load(14, 1'b1, 4'hF); tick();
    tb_dq = pat(14, 40); tb_drive = 1'b1; model[14] = tb_dq;
    op_load(15, 1'b1, 4'hF); tick();
    tb_dq = pat(15, 41); model[15] = tb_dq;
    op_load(14, 1'b0, 4'h0); tick();
    tb_drive = 1'b0; #1;
    check("R7 read behind second pending write", data, model[14]);
    op_load(15, 1'b0, 4'h0); tick(); #1;
    check("R7 read of just-committed word", data, model[15]);
    op_desel(); tick();

    // R3: asynchronous output enable
    op_load(5, 1'b0, 4'h0); tick();
    out_en_n = 1'b1;
    expect_hiz("R3 out_en_n high releases bus");
    out_en_n = 1'b0; #1;
    check("R3 out_en_n low restores read", data, model[5]);
    op_desel(); tick();

    // R1: stalled edges during a read
    op_load(10, 1'b0, 4'h0); tick(); #1;
    check("R1 read before stall", data, model[10]);
    stall = 1'b1; op_load(20, 1'b1, 4'hF); tick(); #1;
    check("R1 stalled edge keeps read", data, model[10]);
    tick(); #1;
    check("R1 second stalled edge keeps read", data, model[10]);
    stall = 1'b0; op_desel(); tick();

    // R1: stalled edges between write address and its data
    op_load(11, 1'b1, 4'hF); tick();
    stall = 1'b1; tb_dq = pat(99, 7); tb_drive = 1'b1;
    op_load(30, 1'b0, 4'h0);
    tick(); tick();
    stall = 1'b0; tb_dq = pat(11, 50); model[11] = tb_dq;
    op_load(11, 1'b0, 4'h0); tick();
    tb_drive = 1'b0; #1;
    check("R1/R4 write data taken after stall", data, model[11]);
    op_load(30, 1'b0, 4'h0); tick(); #1;
    check("R1 stalled bus not written", data, model[30]);
    op_desel(); tick();

    // R6/R10: each select inactive in turn
    for (int k = 0; k < 3; k++) begin
      op_load(12, 1'b0, 4'h0);
      if (k == 0) sel_a_n = 1'b1; else if (k == 1) sel_b = 1'b0; else sel_c_n = 1'b1;
      tick();
      expect_hiz("R6 deselected read start");
      op_adv(4'h0); tick();
      expect_hiz("R10 advance after deselect");
      op_load(13, 1'b1, 4'hF);
      if (k == 0) sel_a_n = 1'b1; else if (k == 1) sel_b = 1'b0; else sel_c_n = 1'b1;
      tick();
      tb_dq = pat(77, k); tb_drive = 1'b1;
      op_load(13, 1'b0, 4'h0); tick();
      tb_drive = 1'b0; #1;
      check("R6 deselected write changes nothing", data, model[13]);
      op_desel(); tick();
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule